// File: doc/BRIEF.md
# Accelerator Control and Status Register File

This block is the host-facing register file of a compute kernel. A host on an AXI4-Lite bus uses it to launch the kernel, watch its progress and hand it scalar arguments. The kernel core is reached through five handshake wires: start and continue leave the block, and done, idle and ready come back. A single interrupt line tells the host about completion and input-consumed events. A two-level enable gates it: one global switch and one switch per channel.

A build-time parameter picks one of two control disciplines. In sequential mode a host read of the control word clears the done flag. In chain mode a one-cycle continue pulse, issued by the host, clears done instead, so batches may overlap. An auto-restart bit keeps start raised across ready handshakes. In chain mode it also keeps continue raised. Arguments sit in 64-bit slots placed after the four fixed registers. Slots marked narrow by a parameter keep only their low word.

Top module: `kctl_regs`

## Requirements
- R1: After reset every register reads 0, the start, continue and interrupt outputs are low, and no bus response is pending.
- R2: The write address and write data are accepted independently and in either order. Every write and read response is OKAY (code 2'b00).
- R3: Control word offset 0x0, bit 0 is start. A host write with bit 0 = 1 sets it and drives the start output. Writing 0 does not clear it. A ready pulse from the core clears it, unless auto-restart (bit 7, read/write) is set, in which case start stays high.
- R4: Bit 1 of the control word is done. A done pulse from the core sets it. In sequential mode, the read that reports done = 1 clears it.
- R5: In chain mode, writing 1 to bit 4 raises the continue output for exactly one cycle. Bit 4 reads back 0 after that cycle. That continue clears done, and a read leaves done unchanged. With auto-restart set, continue stays high. In sequential mode bit 4 has no effect and reads 0.
- R6: Bit 3 of the control word is ready. A ready pulse from the core sets it, and the next read of the control word clears it. Bit 2 (idle) follows the core idle input, one clock later.
- R7: A done pulse in the same cycle as a control-word read is kept: that read may show done = 0, but the next read shows done = 1.
- R8: Control bits 1, 2, 3, 5, 6 and 8-31 ignore host writes. Offset 0x4 bit 0 is the global interrupt enable. Offset 0x8 bits 1:0 are the channel enables. All other bits of these registers read 0.
- R9: Offset 0xC holds the interrupt status. Bit 0 (channel done) is set by a done pulse only when enable bit 0 is set. Bit 1 (channel ready) is set by a ready pulse only when enable bit 1 is set. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: The interrupt output is high exactly when the global enable is set and some status bit is set together with its enable bit. It changes on the same clock edge as those registers.
- R11: Argument slot i has its low word at 0x10+8i and its high word at 0x14+8i. Writes honour the byte strobes. A slot whose bit is 0 in the wide-slot mask keeps its high word at 0, ignores writes to it and reads it as 0. Slot i drives args_o[64i+63:64i] as {high, low}.
- R12: Offsets past the last argument slot read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start | output | 1 | Start request to the kernel core |
| core_continue | output | 1 | Continue request to the kernel core (chain mode) |
| core_done | input | 1 | Done pulse from the core |
| core_idle | input | 1 | Idle level from the core |
| core_ready | input | 1 | Ready pulse from the core |
| args_o | output | 64*NUM_ARGS | Argument slot contents |
| irq | output | 1 | Interrupt, active high |

## Verification
Most internal faults in this block reach the ports within one or two clock edges. A status or enable bit with the wrong value moves the interrupt line on the edge after the offending core pulse or host write. A start flag that clears too early or too late shows on core_start one edge after the ready pulse. Errors in the clear-on-read and continue rules stay hidden until the host reads the control word. They are therefore checked with back-to-back reads and with a done pulse placed in the very cycle of a read.

// File: rtl/kctl_pkg.sv
package kctl_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_GIE  = 1;
  localparam int OFS_IER  = 2;
  localparam int OFS_ISR  = 3;
  localparam int ARG_BASE_WORD = 4;

  localparam int CB_START = 0;
  localparam int CB_DONE  = 1;
  localparam int CB_IDLE  = 2;
  localparam int CB_READY = 3;
  localparam int CB_CONT  = 4;
  localparam int CB_AUTO  = 7;

  localparam int CH_DONE  = 0;
  localparam int CH_READY = 1;
  localparam int NUM_CH   = 2;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_GIE  = 3'd1,
    SEL_IER  = 3'd2,
    SEL_ISR  = 3'd3,
    SEL_ARG  = 3'd4,
    SEL_NONE = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/kctl_axil.sv
module kctl_axil #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                awvalid,
  output logic                awready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic                wvalid,
  output logic                wready,
  output logic [1:0]          bresp,
  output logic                bvalid,
  input  logic                bready,
  input  logic                arvalid,
  output logic                arready,
  output logic [DATA_W-1:0]   rdata,
  output logic [1:0]          rresp,
  output logic                rvalid,
  input  logic                rready,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W/8-1:0] wr_strb,
  output logic                rd_en,
  input  logic [DATA_W-1:0]   rd_word
);
  localparam int STRB_W = DATA_W / 8;

  logic                aw_have, w_have, bvalid_q, rvalid_q;
  logic [ADDR_W-1:0]   aw_q;
  logic [DATA_W-1:0]   w_q, rdata_q;
  logic [STRB_W-1:0]   s_q;

  assign awready = !aw_have && !bvalid_q;
  assign wready  = !w_have && !bvalid_q;
  assign wr_en   = aw_have && w_have && !bvalid_q;
  assign wr_addr = aw_q;
  assign wr_data = w_q;
  assign wr_strb = s_q;
  assign bvalid  = bvalid_q;
  assign bresp   = 2'b00;

  assign arready = !rvalid_q;
  assign rd_en   = arvalid && !rvalid_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_have  <= 1'b0;
      w_have   <= 1'b0;
      bvalid_q <= 1'b0;
      aw_q     <= '0;
      w_q      <= '0;
      s_q      <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_have <= 1'b1;
        aw_q    <= awaddr;
      end
      if (wvalid && wready) begin
        w_have <= 1'b1;
        w_q    <= wdata;
        s_q    <= wstrb;
      end
      if (wr_en) begin
        aw_have  <= 1'b0;
        w_have   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_en) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_word;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end

  // R2: a pending write response stays until accepted
  assert_bhold_R2: assert property (@(posedge clk) disable iff (rst)
    (bvalid_q && !bready) |=> bvalid_q);

  // R2: read data is held stable while not accepted
  assert_rhold_R2: assert property (@(posedge clk) disable iff (rst)
    (rvalid_q && !rready) |=> (rvalid_q && $stable(rdata_q)));
endmodule

// File: rtl/kctl_ctrl.sv
module kctl_ctrl
  import kctl_pkg::*;
#(
  parameter bit CHAIN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_gie,
  input  logic              wr_ier,
  input  logic              wr_isr,
  input  logic [7:0]        wd,
  input  logic              rd_ctrl,
  input  logic              core_done,
  input  logic              core_idle,
  input  logic              core_ready,
  output logic              core_start,
  output logic              core_continue,
  output logic              irq,
  output logic [7:0]        ctrl_word,
  output logic              gie,
  output logic [NUM_CH-1:0] ier,
  output logic [NUM_CH-1:0] isr
);
  logic start_r, done_r, idle_r, ready_r, cont_r, auto_r, gie_r, irq_r;
  logic [NUM_CH-1:0] ier_r, isr_r;

  logic start_n, done_n, ready_n, cont_n, auto_n, gie_n, irq_n;
  logic [NUM_CH-1:0] ier_n, isr_n, ev, w1c;
  logic host_start, host_cont, done_clr;

  logic unused_wd;
  assign unused_wd = ^{wd[6:5], wd[3:2]};

  assign host_start = wr_ctrl && wd[CB_START];
  assign host_cont  = wr_ctrl && wd[CB_CONT];

  // The mode picks what retires the done flag
  generate
    if (CHAIN) begin : g_chain
      assign done_clr = cont_r;
    end else begin : g_seq
      assign done_clr = rd_ctrl;
    end
  endgenerate

  always_comb begin
    auto_n  = wr_ctrl ? wd[CB_AUTO] : auto_r;
    start_n = host_start || (start_r && !(core_ready && !auto_r));
    cont_n  = CHAIN && (host_cont || auto_n);
    done_n  = core_done || (done_r && !done_clr);
    ready_n = core_ready || (ready_r && !rd_ctrl);
    gie_n   = wr_gie ? wd[0] : gie_r;
    ier_n   = wr_ier ? wd[NUM_CH-1:0] : ier_r;
    ev      = '0;
    ev[CH_DONE]  = core_done;
    ev[CH_READY] = core_ready;
    w1c     = wr_isr ? wd[NUM_CH-1:0] : '0;
    isr_n   = (ev & ier_r) | (isr_r & ~w1c);
    irq_n   = gie_n && |(isr_n & ier_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_r <= 1'b0;
      done_r  <= 1'b0;
      idle_r  <= 1'b0;
      ready_r <= 1'b0;
      cont_r  <= 1'b0;
      auto_r  <= 1'b0;
      gie_r   <= 1'b0;
      ier_r   <= '0;
      isr_r   <= '0;
      irq_r   <= 1'b0;
    end else begin
      start_r <= start_n;
      done_r  <= done_n;
      idle_r  <= core_idle;
      ready_r <= ready_n;
      cont_r  <= cont_n;
      auto_r  <= auto_n;
      gie_r   <= gie_n;
      ier_r   <= ier_n;
      isr_r   <= isr_n;
      irq_r   <= irq_n;
    end
  end

  assign core_start    = start_r;
  assign core_continue = cont_r;
  assign irq           = irq_r;
  assign gie           = gie_r;
  assign ier           = ier_r;
  assign isr           = isr_r;
  assign ctrl_word     = {auto_r, 2'b00, cont_r, ready_r, idle_r, done_r, start_r};

  // R3: start only drops on a ready pulse without auto-restart
  assert_start_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (start_r && !core_ready) |=> start_r);

  // R3: a ready pulse retires start when auto-restart is off
  assert_start_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (start_r && core_ready && !auto_r && !host_start) |=> !start_r);

  // R5: a host continue lasts one cycle unless auto-restart holds it
  assert_cont_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (cont_r && !auto_r && !wr_ctrl) |=> !cont_r);

  // R7: a done pulse is never lost, whatever the host does
  assert_done_keep_R7: assert property (@(posedge clk) disable iff (rst)
    core_done |=> done_r);

  // R9: a status bit rises only for an enabled event
  assert_isr_enable_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(isr_r[CH_DONE]) |-> $past(ier_r[CH_DONE] && core_done));

  // R10: interrupt implies both enable levels and a pending status
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    irq_r |-> (gie_r && |(isr_r & ier_r)));
endmodule

// File: rtl/kctl_args.sv
module kctl_args #(
  parameter int NUM_ARGS = 4,
  parameter logic [NUM_ARGS-1:0] WIDE_ARGS = '1,
  parameter int IDX_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [31:0]           wr_data,
  input  logic [3:0]            wr_strb,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [31:0]           rd_word,
  output logic [64*NUM_ARGS-1:0] args_flat
);
  logic [31:0] lo_w [NUM_ARGS];
  logic [31:0] hi_w [NUM_ARGS];

  for (genvar i = 0; i < NUM_ARGS; i++) begin : g_slot
    localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(2 * i);
    localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(2 * i + 1);
    logic [31:0] lo_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
      end else if (wr_en && wr_idx == LO_IDX) begin
        for (int b = 0; b < 4; b++)
          if (wr_strb[b]) lo_q[8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
    assign lo_w[i] = lo_q;

    if (WIDE_ARGS[i]) begin : g_wide
      logic [31:0] hi_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          hi_q <= '0;
        end else if (wr_en && wr_idx == HI_IDX) begin
          for (int b = 0; b < 4; b++)
            if (wr_strb[b]) hi_q[8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
      assign hi_w[i] = hi_q;
    end else begin : g_narrow
      assign hi_w[i] = '0;
    end

    assign args_flat[64*i +: 64] = {hi_w[i], lo_w[i]};
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_ARGS; i++) begin
      if (rd_idx == IDX_W'(2 * i))     rd_word = lo_w[i];
      if (rd_idx == IDX_W'(2 * i + 1)) rd_word = hi_w[i];
    end
  end
endmodule

// File: rtl/kctl_regs.sv
module kctl_regs
  import kctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_ARGS = 4,
  parameter logic [NUM_ARGS-1:0] WIDE_ARGS = 4'b0101,
  parameter bit CHAIN = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      s_awaddr,
  input  logic                   s_awvalid,
  output logic                   s_awready,
  input  logic [31:0]            s_wdata,
  input  logic [3:0]             s_wstrb,
  input  logic                   s_wvalid,
  output logic                   s_wready,
  output logic [1:0]             s_bresp,
  output logic                   s_bvalid,
  input  logic                   s_bready,
  input  logic [ADDR_W-1:0]      s_araddr,
  input  logic                   s_arvalid,
  output logic                   s_arready,
  output logic [31:0]            s_rdata,
  output logic [1:0]             s_rresp,
  output logic                   s_rvalid,
  input  logic                   s_rready,
  output logic                   core_start,
  output logic                   core_continue,
  input  logic                   core_done,
  input  logic                   core_idle,
  input  logic                   core_ready,
  output logic [64*NUM_ARGS-1:0] args_o,
  output logic                   irq
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int ARG_WORDS = 2 * NUM_ARGS;
  localparam int ARG_END   = ARG_BASE_WORD + ARG_WORDS;

  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data, rd_word, arg_rd;
  logic [3:0]        wr_strb;
  logic [WORD_W-1:0] wr_word, rd_wordaddr, wr_idx, rd_idx;
  reg_sel_e          wsel, rsel;
  logic [7:0]        ctrl_word;
  logic              gie;
  logic [NUM_CH-1:0] ier, isr;

  logic unused_lsb;
  assign unused_lsb = ^{wr_addr[1:0], s_araddr[1:0]};

  assign wr_word     = wr_addr[ADDR_W-1:2];
  assign rd_wordaddr = s_araddr[ADDR_W-1:2];
  assign wr_idx      = wr_word - WORD_W'(ARG_BASE_WORD);
  assign rd_idx      = rd_wordaddr - WORD_W'(ARG_BASE_WORD);

  function automatic reg_sel_e decode(input logic [WORD_W-1:0] w);
    if (w == WORD_W'(OFS_CTRL))                       return SEL_CTRL;
    else if (w == WORD_W'(OFS_GIE))                   return SEL_GIE;
    else if (w == WORD_W'(OFS_IER))                   return SEL_IER;
    else if (w == WORD_W'(OFS_ISR))                   return SEL_ISR;
    else if ({1'b0, w} < (WORD_W+1)'(ARG_END))        return SEL_ARG;
    else                                              return SEL_NONE;
  endfunction

  assign wsel = decode(wr_word);
  assign rsel = decode(rd_wordaddr);

  always_comb begin
    case (rsel)
      SEL_CTRL: rd_word = {24'b0, ctrl_word};
      SEL_GIE:  rd_word = {31'b0, gie};
      SEL_IER:  rd_word = {{(32-NUM_CH){1'b0}}, ier};
      SEL_ISR:  rd_word = {{(32-NUM_CH){1'b0}}, isr};
      SEL_ARG:  rd_word = arg_rd;
      default:  rd_word = '0;
    endcase
  end

  kctl_axil #(.ADDR_W(ADDR_W), .DATA_W(32)) u_bus (
    .clk     (clk),
    .rst     (rst),
    .awaddr  (s_awaddr),
    .awvalid (s_awvalid),
    .awready (s_awready),
    .wdata   (s_wdata),
    .wstrb   (s_wstrb),
    .wvalid  (s_wvalid),
    .wready  (s_wready),
    .bresp   (s_bresp),
    .bvalid  (s_bvalid),
    .bready  (s_bready),
    .arvalid (s_arvalid),
    .arready (s_arready),
    .rdata   (s_rdata),
    .rresp   (s_rresp),
    .rvalid  (s_rvalid),
    .rready  (s_rready),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_strb (wr_strb),
    .rd_en   (rd_en),
    .rd_word (rd_word)
  );

  kctl_ctrl #(.CHAIN(CHAIN)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .wr_ctrl       (wr_en && wr_strb[0] && wsel == SEL_CTRL),
    .wr_gie        (wr_en && wr_strb[0] && wsel == SEL_GIE),
    .wr_ier        (wr_en && wr_strb[0] && wsel == SEL_IER),
    .wr_isr        (wr_en && wr_strb[0] && wsel == SEL_ISR),
    .wd            (wr_data[7:0]),
    .rd_ctrl       (rd_en && rsel == SEL_CTRL),
    .core_done     (core_done),
    .core_idle     (core_idle),
    .core_ready    (core_ready),
    .core_start    (core_start),
    .core_continue (core_continue),
    .irq           (irq),
    .ctrl_word     (ctrl_word),
    .gie           (gie),
    .ier           (ier),
    .isr           (isr)
  );

  kctl_args #(.NUM_ARGS(NUM_ARGS), .WIDE_ARGS(WIDE_ARGS), .IDX_W(WORD_W)) u_args (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en && wsel == SEL_ARG),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .wr_strb   (wr_strb),
    .rd_idx    (rd_idx),
    .rd_word   (arg_rd),
    .args_flat (args_o)
  );

  // R12: the unmapped region never returns data
  assert_hole_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rsel == SEL_NONE) |=> (s_rdata == 32'd0));
endmodule

// File: tb/kctl_regs_test.sv
module kctl_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, arvalid = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        k_done = 0, k_idle = 0, k_ready = 0;

  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata, rdata_ch;
  logic        start_hs, cont_hs, irq_hs;
  logic        start_ch, cont_ch, irq_ch;
  logic [255:0] args_hs, args_ch;
  logic        awready_c, wready_c, bvalid_c, arready_c, rvalid_c;
  logic [1:0]  bresp_c, rresp_c;

  kctl_regs #(.CHAIN(1'b0)) uut (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
    .core_start(start_hs), .core_continue(cont_hs),
    .core_done(k_done), .core_idle(k_idle), .core_ready(k_ready),
    .args_o(args_hs), .irq(irq_hs));

  kctl_regs #(.CHAIN(1'b1)) uut_ch (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready_c),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready_c),
    .s_bresp(bresp_c), .s_bvalid(bvalid_c), .s_bready(1'b1),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready_c),
    .s_rdata(rdata_ch), .s_rresp(rresp_c), .s_rvalid(rvalid_c), .s_rready(1'b1),
    .core_start(start_ch), .core_continue(cont_ch),
    .core_done(k_done), .core_idle(k_idle), .core_ready(k_ready),
    .args_o(args_ch), .irq(irq_ch));

  int checks = 0;
  int errors = 0;
  int cont_cnt_hs = 0;
  int cont_cnt_ch = 0;
  logic [1:0]  last_bresp;
  logic [31:0] r_hs, r_ch;

  always @(negedge clk) begin
    if (cont_hs) cont_cnt_hs++;
    if (cont_ch) cont_cnt_ch++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // order: 0 both, 1 data first, 2 address first
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s, input int order = 0);
    logic ha, hw;
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s;
    awvalid = (order != 1);
    wvalid  = (order != 2);
    while (awvalid || wvalid) begin
      ha = awvalid && awready;
      hw = wvalid && wready;
      @(posedge clk);
      @(negedge clk);
      if (ha) begin awvalid = 0; if (order == 1) wvalid = 0; end
      if (hw) begin wvalid = 0; if (order == 1) awvalid = 1; end
      if (order == 2 && ha) wvalid = 1;
      if (order == 1) order = 0;
      if (order == 2 && ha) order = 0;
    end
    while (!bvalid) @(negedge clk);
    last_bresp = bresp;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    araddr = a; arvalid = 1;
    while (!arready) begin @(posedge clk); @(negedge clk); end
    @(posedge clk);
    @(negedge clk);
    arvalid = 0;
    r_hs = rdata; r_ch = rdata_ch;
    checks++;
    if (rresp !== 2'b00) begin errors++; $display("FAIL R2: rresp got %0h expected 0", rresp); end
  endtask

  task automatic pulse_done();
    @(negedge clk); k_done = 1; @(negedge clk); k_done = 0;
  endtask
  task automatic pulse_ready();
    @(negedge clk); k_ready = 1; @(negedge clk); k_ready = 0;
  endtask

  // {address, write data, strobes, expected readback} for R11 and R12
  localparam logic [75:0] VEC [0:8] = '{
    {8'h10, 32'h11223344, 4'hF, 32'h11223344},
    {8'h14, 32'hAABBCCDD, 4'hF, 32'hAABBCCDD},
    {8'h10, 32'hFFFFFFFF, 4'h2, 32'h1122FF44},
    {8'h1C, 32'hDEADBEEF, 4'hF, 32'h00000000},
    {8'h18, 32'h0BADF00D, 4'hC, 32'h0BAD0000},
    {8'h24, 32'h12345678, 4'h9, 32'h12000078},
    {8'h2C, 32'h55555555, 4'hF, 32'h00000000},
    {8'h30, 32'h77777777, 4'hF, 32'h00000000},
    {8'h28, 32'hCAFEF00D, 4'hF, 32'hCAFEF00D}
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    check("R1 start", {start_hs, start_ch}, 0);
    check("R1 irq/cont", {irq_hs, irq_ch, cont_hs, cont_ch}, 0);
    check("R1 no response", {bvalid, rvalid}, 0);
    rd(8'h00); check("R1 ctrl", {r_hs, r_ch}, 0);
    rd(8'h0C); check("R1 isr", {r_hs, r_ch}, 0);

    // R11 / R12 vector walk
    foreach (VEC[i]) begin
      wr(VEC[i][75:68], VEC[i][67:36], VEC[i][35:32]);
      check("R2 bresp", last_bresp, 2'b00);
      rd(VEC[i][75:68]);
      check(VEC[i][75:68] >= 8'h30 ? "R12 hole" : "R11 arg", r_hs, VEC[i][31:0]);
    end
    check("R11 slot0 out", args_hs[63:0], 64'hAABBCCDD_1122FF44);
    check("R11 slot1 out", args_hs[127:64], 64'h00000000_0BAD0000);

    // R2 data before address and address before data
    wr(8'h20, 32'h01020304, 4'hF, 1);
    rd(8'h20); check("R2 data first", r_hs, 32'h01020304);
    wr(8'h20, 32'h0A0B0C0D, 4'hF, 2);
    rd(8'h20); check("R2 addr first", r_hs, 32'h0A0B0C0D);

    // R6 idle follows the core
    k_idle = 1;
    rd(8'h00); check("R6 idle", {r_hs, r_ch}, {32'h04, 32'h04});

    // R3 start set, write 0 ignored, ready clears
    wr(8'h00, 32'h1, 4'h1);
    check("R3 start set", {start_hs, start_ch}, 2'b11);
    wr(8'h00, 32'h0, 4'h1);
    check("R3 write0 ignored", {start_hs, start_ch}, 2'b11);
    pulse_ready();
    check("R3 ready clears", {start_hs, start_ch}, 2'b00);
    rd(8'h00); check("R6 ready reported", {r_hs, r_ch}, {32'h0C, 32'h0C});
    rd(8'h00); check("R6 ready cleared", {r_hs, r_ch}, {32'h04, 32'h04});

    // R4 / R5 done rules per mode
    pulse_done();
    rd(8'h00); check("R4 done seen", {r_hs, r_ch}, {32'h06, 32'h06});
    rd(8'h00); check("R4 R5 read clear rule", {r_hs, r_ch}, {32'h04, 32'h06});
    cont_cnt_hs = 0; cont_cnt_ch = 0;
    wr(8'h00, 32'h10, 4'h1);
    repeat (3) @(negedge clk);
    check("R5 continue one cycle", cont_cnt_ch, 1);
    check("R5 no continue in seq", cont_cnt_hs, 0);
    rd(8'h00); check("R5 continue clears done", {r_hs, r_ch}, {32'h04, 32'h04});

    // R8 read-only and reserved bits, enable registers
    wr(8'h00, 32'hFFFFFF6E, 4'hF);
    rd(8'h00); check("R8 ro bits", {r_hs, r_ch}, {32'h04, 32'h04});
    wr(8'h04, 32'hFFFFFFFF, 4'hF);
    wr(8'h08, 32'hFFFFFFFF, 4'hF);
    rd(8'h04); check("R8 gie", r_hs, 32'h1);
    rd(8'h08); check("R8 ier", r_hs, 32'h3);
    wr(8'h04, 32'h0, 4'hF);
    wr(8'h08, 32'h0, 4'hF);

    // R3 / R5 auto-restart
    wr(8'h00, 32'h81, 4'h1);
    pulse_ready();
    check("R3 auto holds start", {start_hs, start_ch}, 2'b11);
    check("R5 auto holds continue", {cont_hs, cont_ch}, 2'b01);
    rd(8'h00); check("R3 auto readback", r_hs, 32'h8D);
    wr(8'h00, 32'h00, 4'h1);
    pulse_ready();
    check("R3 start clears after auto off", {start_hs, start_ch}, 2'b00);
    check("R5 continue drops", cont_ch, 0);
    rd(8'h00);
    rd(8'h0C); check("R9 disabled no status", {r_hs, r_ch}, 0);

    // R9 / R10 interrupt path
    wr(8'h08, 32'h1, 4'hF);
    pulse_ready();
    pulse_done();
    rd(8'h0C); check("R9 done channel only", r_hs, 32'h1);
    check("R10 gie off", irq_hs, 0);
    wr(8'h04, 32'h1, 4'hF);
    check("R10 gie on", {irq_hs, irq_ch}, 2'b11);
    wr(8'h0C, 32'h2, 4'hF);
    rd(8'h0C); check("R9 w0 keeps", r_hs, 32'h1);
    wr(8'h0C, 32'h1, 4'hF);
    check("R10 irq drops", {irq_hs, irq_ch}, 2'b00);
    wr(8'h08, 32'h2, 4'hF);
    pulse_ready();
    check("R10 ready channel irq", irq_hs, 1);
    rd(8'h0C); check("R9 ready status", r_hs, 32'h2);
    wr(8'h0C, 32'h3, 4'hF);
    check("R9 w1c", irq_hs, 0);

    // R7 done pulse in the read cycle
    rd(8'h00); rd(8'h00);
    @(negedge clk);
    araddr = 8'h00; arvalid = 1; k_done = 1;
    @(posedge clk);
    @(negedge clk);
    arvalid = 0; k_done = 0;
    check("R7 race read", rdata[1], 1'b0);
    rd(8'h00); check("R7 done kept", r_hs[1], 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule